// File: doc/BRIEF.md
# Three-Wire Serial Master Sequencer

This block runs one complete transaction on a three-wire synchronous serial link: a serial clock (SK), a master-to-slave data line (SO) and a slave-to-master data line (SI), plus one active-low chip select. A host pulses `start` together with a frame description. The block then selects the slave and clocks out a frame, bit by bit. The frame is an optional leading `1` start bit, an address/instruction field of run-time length, and then either a write data field or a read data field. For a read, one idle bit time is allowed for the slave's leading dummy zero. After the last bit the block deselects the slave and pulses `done`.

The serial clock is made from the system clock. Each half period of SK lasts `DIV` system clocks. The master changes SO only while SK is low, so a slave can latch it on the rising edge. The master samples SI on the same rising edge. Bits go out most significant first. Read data is assembled so that the first bit received ends up in the highest valid bit of `rdata`.

Top module: `wm_master`

## Requirements
- R1: SO changes only in cycles where SK is low. SO holds its value on every clock where SK rises.
- R2: In a read, SI is sampled on each SK rising edge of the data field. The result appears in `rdata`, first bit received in bit `data_len-1` and last bit in bit 0. All higher bits of `rdata` are zero.
- R3: With `framed`=1, the bit sequence on SO is a single `1`, then `addr` bits `addr_len-1` down to 0, then (write) `wdata` bits `data_len-1` down to 0.
- R4: With `framed`=0, no start bit is sent. The first SK rise carries the address MSB, or the data MSB when `addr_len`=0.
- R5: After reset and whenever `busy` is low, `cs_n`=1, `sk`=0 and `so`=0.
- R6: `addr_len` may be 0 to 16 and `data_len` 1 to 64. A transaction gives exactly framed + addr_len + rd_mode + data_len SK rising edges.
- R7: `cs_n` goes low with SK and SO low, and 2·DIV clocks pass before the first SK rise. Each SK phase lasts DIV clocks, so `busy` is high for DIV·(2·bits+2) clocks.
- R8: With `rd_mode`=1, one bit time follows the address in which SO is low and SI is not captured. SO stays low through the read data field.
- R9: `done` is high for exactly one clock: the first clock in which `cs_n` is high again, with `busy` already low.
- R10: A `start` pulse while `busy` is high is ignored. The running frame is unchanged and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| framed | input | 1 | 1: prefix a start bit; 0: raw bit stream |
| rd_mode | input | 1 | 1: read data field after a turnaround bit; 0: write |
| addr_len | input | $clog2(ADDR_MAX+1) | Address field length in bits (0..ADDR_MAX) |
| data_len | input | $clog2(DATA_MAX+1) | Data field length in bits (1..DATA_MAX) |
| addr | input | ADDR_MAX | Address/instruction field, right-aligned |
| wdata | input | DATA_MAX | Write data, right-aligned |
| si | input | 1 | Serial data from slave |
| cs_n | output | 1 | Active-low chip select |
| sk | output | 1 | Serial clock |
| so | output | 1 | Serial data to slave |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_MAX | Captured read data, right-aligned |

## Verification
The bench builds the block with DIV=2, ADDR_MAX=16 and DATA_MAX=64. With DIV=2 each SK phase is two clocks wide, so the select-to-first-edge gap and the per-bit phase counts can be told apart from a single-cycle design. With the full-width defaults the bench can run the 64-bit data field and the 16-bit address field at their limits. A bench slave replies with a known pattern. The pattern has a `1` in the turnaround slot, so a capture that is off by one bit shows up in `rdata`.

// File: rtl/wm_pkg.sv
package wm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEL,
    ST_BITS,
    ST_TAIL
  } wm_state_e;

  typedef enum logic [2:0] {
    K_START,
    K_ADDR,
    K_TURN,
    K_WDATA,
    K_RDATA
  } wm_kind_e;

endpackage

// File: rtl/wm_tick.sv
module wm_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wm_bitsel.sv
module wm_bitsel
  import wm_pkg::*;
#(
  parameter int ADDR_MAX = 16,
  parameter int DATA_MAX = 64,
  parameter int PW  = 7,
  parameter int ALW = 5,
  parameter int DLW = 7
) (
  input  logic [PW-1:0]       pos,
  input  logic                framed,
  input  logic                rd,
  input  logic [ALW-1:0]      alen,
  input  logic [DLW-1:0]      dlen,
  input  logic [ADDR_MAX-1:0] addr,
  input  logic [DATA_MAX-1:0] wdata,
  output logic                bit_o,
  output wm_kind_e            kind_o
);
  localparam int AIW = (ADDR_MAX > 1) ? $clog2(ADDR_MAX) : 1;
  localparam int DIW = (DATA_MAX > 1) ? $clog2(DATA_MAX) : 1;

  logic [PW-1:0]  e_start, e_addr, e_turn, total;
  logic [AIW-1:0] ai;
  logic [DIW-1:0] di;

  always_comb begin
    e_start = PW'(framed);
    e_addr  = e_start + PW'(alen);
    e_turn  = e_addr + PW'(rd);
    total   = e_turn + PW'(dlen);
    ai      = AIW'(e_addr - pos - 1'b1);
    di      = DIW'(total - pos - 1'b1);
    if (pos < e_start) begin
      kind_o = K_START;
      bit_o  = 1'b1;
    end else if (pos < e_addr) begin
      kind_o = K_ADDR;
      bit_o  = addr[ai];
    end else if (pos < e_turn) begin
      kind_o = K_TURN;
      bit_o  = 1'b0;
    end else if (rd) begin
      kind_o = K_RDATA;
      bit_o  = 1'b0;
    end else begin
      kind_o = K_WDATA;
      bit_o  = wdata[di];
    end
  end
endmodule

// File: rtl/wm_master.sv
module wm_master
  import wm_pkg::*;
#(
  parameter int DIV      = 2,
  parameter int ADDR_MAX = 16,
  parameter int DATA_MAX = 64,
  localparam int ALW = $clog2(ADDR_MAX + 1),
  localparam int DLW = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                framed,
  input  logic                rd_mode,
  input  logic [ALW-1:0]      addr_len,
  input  logic [DLW-1:0]      data_len,
  input  logic [ADDR_MAX-1:0] addr,
  input  logic [DATA_MAX-1:0] wdata,
  input  logic                si,
  output logic                cs_n,
  output logic                sk,
  output logic                so,
  output logic                busy,
  output logic                done,
  output logic [DATA_MAX-1:0] rdata
);
  localparam int PW = $clog2(ADDR_MAX + DATA_MAX + 3);

  wm_state_e           state;
  logic [PW-1:0]       idx, pos, last;
  logic                framed_q, rd_q;
  logic [ALW-1:0]      alen_q;
  logic [DLW-1:0]      dlen_q;
  logic [ADDR_MAX-1:0] addr_q;
  logic [DATA_MAX-1:0] wdata_q;
  logic                tick, cur_bit;
  wm_kind_e            cur_kind;

  wm_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .tick (tick)
  );

  // Low phase looks at the bit being sampled; otherwise at the next bit to launch.
  always_comb begin
    if (state == ST_BITS && !sk) pos = idx;
    else if (state == ST_BITS)   pos = idx + 1'b1;
    else                         pos = '0;
    last = PW'(framed_q) + PW'(alen_q) + PW'(rd_q) + PW'(dlen_q) - 1'b1;
  end

  wm_bitsel #(
    .ADDR_MAX(ADDR_MAX), .DATA_MAX(DATA_MAX),
    .PW(PW), .ALW(ALW), .DLW(DLW)
  ) u_bitsel (
    .pos    (pos),
    .framed (framed_q),
    .rd     (rd_q),
    .alen   (alen_q),
    .dlen   (dlen_q),
    .addr   (addr_q),
    .wdata  (wdata_q),
    .bit_o  (cur_bit),
    .kind_o (cur_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sk       <= 1'b0;
      so       <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      idx      <= '0;
      rdata    <= '0;
      framed_q <= 1'b0;
      rd_q     <= 1'b0;
      alen_q   <= '0;
      dlen_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            framed_q <= framed;
            rd_q     <= rd_mode;
            alen_q   <= addr_len;
            dlen_q   <= data_len;
            addr_q   <= addr;
            wdata_q  <= wdata;
            cs_n     <= 1'b0;
            so       <= 1'b0;
            busy     <= 1'b1;
            idx      <= '0;
            state    <= ST_SEL;
            if (rd_mode) rdata <= '0;
          end
        end
        ST_SEL: begin
          if (tick) begin
            so    <= cur_bit;
            state <= ST_BITS;
          end
        end
        ST_BITS: begin
          if (tick) begin
            if (!sk) begin
              sk <= 1'b1;
              if (cur_kind == K_RDATA) rdata <= {rdata[DATA_MAX-2:0], si};
            end else begin
              sk <= 1'b0;
              if (idx == last) begin
                so    <= 1'b0;
                state <= ST_TAIL;
              end else begin
                so  <= cur_bit;
                idx <= idx + 1'b1;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wm_master_chk.sv
module wm_master_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cs_n,
  input logic sk,
  input logic so,
  input logic busy,
  input logic done
);
  // R1
  so_launch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(so) |-> !sk);

  // R1
  so_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sk) |-> $stable(so));

  // R5
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sk && !so));

  // R5
  sk_selected_chk: assert property (@(posedge clk) disable iff (rst)
    sk |-> !cs_n);

  // R7
  sel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (!sk && !so));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !busy));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind wm_master wm_master_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .cs_n  (cs_n),
  .sk    (sk),
  .so    (so),
  .busy  (busy),
  .done  (done)
);

// File: tb/wm_master_bench.sv
module wm_master_bench;
  localparam int CLK_NS = 10;
  localparam int TB_DIV = 2;
  localparam int AM = 16;
  localparam int DM = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, framed = 1'b0, rd_mode = 1'b0;
  logic [4:0]  addr_len = '0;
  logic [6:0]  data_len = 7'd1;
  logic [AM-1:0] addr = '0;
  logic [DM-1:0] wdata = '0;
  logic si;
  logic cs_n, sk, so, busy, done;
  logic [DM-1:0] rdata;

  int n_chk = 0, n_fail = 0, cyc = 0, rise_cnt = 0;
  logic [127:0] cap;
  logic [127:0] resp = 128'hC3A5_96F0_1E2D_3C4B_5A69_7887_E1D2_B4F9;

  always #(CLK_NS/2) clk = ~clk;

  wm_master #(.DIV(TB_DIV), .ADDR_MAX(AM), .DATA_MAX(DM)) u_wm_master (
    .clk(clk), .rst(rst), .start(start), .framed(framed), .rd_mode(rd_mode),
    .addr_len(addr_len), .data_len(data_len), .addr(addr), .wdata(wdata),
    .si(si), .cs_n(cs_n), .sk(sk), .so(so), .busy(busy), .done(done),
    .rdata(rdata)
  );

  // Slave model: presents resp MSB first, one bit per SK rise; records SO.
  assign si = resp[127 - (rise_cnt % 128)];
  always @(posedge sk) begin
    cap = {cap[126:0], so};
    rise_cnt = rise_cnt + 1;
  end

  task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run(input logic f, input logic r, input int al, input int dl,
                     input logic [AM-1:0] a, input logic [DM-1:0] w,
                     input int poke, input string tag);
    logic [127:0] exp_so = '0;
    logic [DM-1:0] exp_rd = '0;
    int n, s, t, cycles, pre, guard;
    logic seen_sk;
    s = f ? 1 : 0;
    t = r ? 1 : 0;
    n = s + al + t + dl;
    for (int k = 0; k < n; k++) begin
      logic b;
      if (k < s) b = 1'b1;
      else if (k < s + al) b = a[al - 1 - (k - s)];
      else if (k < s + al + t) b = 1'b0;
      else if (r) b = 1'b0;
      else b = w[dl - 1 - (k - s - al - t)];
      exp_so = {exp_so[126:0], b};
      if (r && k >= s + al + t) exp_rd = {exp_rd[DM-2:0], resp[127 - k]};
    end
    @(negedge clk);
    framed = f; rd_mode = r; addr_len = 5'(al); data_len = 7'(dl);
    addr = a; wdata = w; start = 1'b1;
    rise_cnt = 0; cap = '0;
    @(negedge clk);
    start = 1'b0;
    cycles = 0; pre = 0; seen_sk = 1'b0; guard = 0;
    while (!done && guard < 2000) begin
      if (busy) cycles++;
      if (sk) seen_sk = 1'b1;
      else if (!seen_sk && !cs_n) pre++;
      if (poke > 0 && cycles == poke) begin
        start = 1'b1; framed = ~f; rd_mode = ~r; addr = ~a; wdata = ~w;
      end else start = 1'b0;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(rise_cnt == n, {tag, " R6 edge count"}, 128'(rise_cnt), 128'(n));
    chk(cap == exp_so, {tag, " SO stream"}, cap, exp_so);
    chk(cycles == TB_DIV * (2 * n + 2), {tag, " R7 busy length"},
        128'(cycles), 128'(TB_DIV * (2 * n + 2)));
    chk(pre == 2 * TB_DIV, {tag, " R7 select lead"}, 128'(pre), 128'(2 * TB_DIV));
    if (r) chk(rdata == exp_rd, {tag, " R2 R8 read data"}, 128'(rdata), 128'(exp_rd));
    chk(done && cs_n && !busy && !sk && !so, {tag, " R9 R5 done state"},
        {124'd0, done, cs_n, busy, sk}, {124'd0, 4'b1100});
    @(negedge clk);
    chk(!done && !busy, {tag, " R9 R10 single done"}, {126'd0, done, busy}, 128'd0);
  endtask

  task automatic t_reset;
    chk(cs_n && !sk && !so && !busy && !done, "R5 reset lines",
        {123'd0, cs_n, sk, so, busy, done}, {123'd0, 5'b10000});
  endtask

  task automatic t_framed_write;
    run(1'b1, 1'b0, 6, 16, 16'h002D, 64'h0000_0000_0000_A5C3, 0, "R3 framed write");
  endtask

  task automatic t_raw_write;
    run(1'b0, 1'b0, 8, 8, 16'h00B1, 64'h0000_0000_0000_004E, 0, "R4 raw write");
    run(1'b0, 1'b0, 0, 5, 16'h0000, 64'h0000_0000_0000_0011, 0, "R4 raw no address");
  endtask

  task automatic t_framed_read;
    run(1'b1, 1'b1, 6, 16, 16'h0026, 64'h0, 0, "R8 framed read");
  endtask

  task automatic t_limits;
    run(1'b1, 1'b0, 0, 64, 16'h0, 64'hF00D_1234_8765_CAFE, 0, "R6 max write");
    run(1'b1, 1'b1, 0, 64, 16'h0, 64'h0, 0, "R2 max read");
    run(1'b0, 1'b1, 16, 1, 16'h9A3C, 64'h0, 0, "R6 max address read");
  endtask

  task automatic t_busy_start;
    run(1'b1, 1'b0, 4, 8, 16'h0009, 64'h0000_0000_0000_0096, 7, "R10 start while busy");
  endtask

  initial begin
    cap = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_framed_write();
    t_raw_write();
    t_framed_read();
    t_limits();
    t_busy_start();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule